// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Selectable Oversampling

This block is the receive half of a full-duplex serial channel. It runs on its own receive clock and watches a single serial input line. It finds the start of a character, shifts in eight data bits with the least significant bit first, checks the stop bit, and hands the byte to a one-deep holding register that the host reads. The shift register and the holding register form a double buffer, so one byte can wait for the host while the next one arrives on the line.

A mode pin selects the timing. In divide-by-one mode, every rising edge of the receive clock samples one bit, and bit alignment is assumed to come from outside. In divide-by-16 mode, the receive clock runs at sixteen times the bit rate. The start bit is qualified half a bit after its falling edge. Each later bit is sampled in the middle of its cell, and every transition seen on the line re-aligns the sample phase. The character format is fixed at eight data bits and one stop bit in both modes, so the timing choice does not depend on the format.

The host sees the received byte, a status byte, a ready flag and an error flag. A data read strobe empties the holding register. A status read strobe clears the error bits.

Top module: `async_rx_channel`

## Requirements
- R1: While reset is asserted and after it is released, with the line idle high, `data_out`, `stat_out`, `rx_ready` and `rx_error` are all zero.
- R2: In divide-by-one mode, a low level sampled on a clock edge while idle is taken as the start bit. The next eight edges sample data bits 0 through 7, and the ninth edge samples the stop bit. The byte appears on `data_out`, with `rx_ready` high, right after that ninth edge and not before it.
- R3: In divide-by-16 mode, a start needs a falling edge on the line. If the line is high again 8 receive clocks after the edge, the receiver returns to idle, delivers no character, and decodes the next valid frame correctly.
- R4: In divide-by-16 mode, each bit is sampled 16 clocks after the previous sample. Any line transition during a frame moves the next sample to 8 clocks after that transition, so alternating patterns are decoded correctly with bit periods from 14 to 18 clocks.
- R5: A stop bit sampled low sets the framing-error bit (status bit 1). The character is still loaded when the holding register can take it.
- R6: A character can be shifted in while the previous one waits in the holding register. If the host reads before the new character completes, the new byte is loaded with no error. `data_out` changes only when a character is loaded.
- R7: If a character completes while the holding register is full and no data read happens in that cycle, the overrun bit (status bit 2) is set, the new character is dropped, and `data_out` keeps the unread byte.
- R8: A data read pulse clears `rx_ready`. If a data read and a character completion fall in the same cycle, the new byte is loaded, `rx_ready` stays high and no overrun is reported.
- R9: A status read pulse clears the framing-error and overrun bits and leaves `rx_ready` unchanged. When a status read and a new framing error fall in the same cycle, the error is set. Error bits stay set until a status read.
- R10: The status byte has ready at bit 0, framing error at bit 1 and overrun at bit 2, with bits 7 to 3 at zero. `rx_error` is high whenever bit 1 or bit 2 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rx_clk | input | 1 | Receive clock (the bit clock, or 16 times the bit rate) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| div16_sel | input | 1 | 1 selects divide-by-16 oversampling, 0 selects divide-by-one |
| rxd | input | 1 | Serial data line, idle high |
| rd_data | input | 1 | One-cycle pulse: host reads the data register |
| rd_stat | input | 1 | One-cycle pulse: host reads the status register |
| data_out | output | 8 | Holding register contents |
| stat_out | output | 8 | Status byte: bit 0 ready, bit 1 framing error, bit 2 overrun |
| rx_ready | output | 1 | A received byte is waiting |
| rx_error | output | 1 | Framing error or overrun is pending |

## Verification
Two pairs of events can land on the same clock edge. A character can complete in the same cycle as a data read, and a framing error can be set in the same cycle as a status read. The bench uses divide-by-one mode, where the stop-bit edge is known exactly, and drives the read strobe on the cycle that samples the stop bit. It then checks that the new byte is present with ready still set and no overrun, and that the new framing error survives the status read. Random frames in both modes, with occasional bad stop bits, are checked against a model of the bytes and status the bench expects.

// File: rtl/rx_pkg.sv
package rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;

  localparam int STAT_W     = 8;
  localparam int STAT_READY = 0;
  localparam int STAT_FERR  = 1;
  localparam int STAT_OVR   = 2;

endpackage

// File: rtl/rx_reset_sync.sv
module rx_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = pipe_q[STAGES-1];

endmodule

// File: rtl/rx_bit_timer.sv
// Sample-phase counter. In oversampling mode it produces one sample tick
// per bit cell, and it can be re-centred by the frame FSM (arm) or by a
// line transition (resync). In divide-by-one mode every clock is a tick.
module rx_bit_timer #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ovs_mode,
  input  logic rxd,
  input  logic arm,
  input  logic resync_en,
  output logic tick,
  output logic fall,
  output logic line_edge
);

  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          prev_q;
  logic          cnt_en;

  assign line_edge = rxd ^ prev_q;
  assign fall      = prev_q & ~rxd;
  assign tick      = ovs_mode ? (cnt_q == LAST) : 1'b1;
  assign cnt_en    = ovs_mode;

  always_comb begin
    if (cnt_q == LAST) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
    if (arm) begin
      cnt_d = MID;
    end else if (resync_en && line_edge && !tick) begin
      cnt_d = MID;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
    end else begin
      prev_q <= rxd;
    end
  end

endmodule

// File: rtl/rx_frame_fsm.sv
// Frame sequencer: start qualification, LSB-first shifting, stop check.
module rx_frame_fsm
  import rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ovs_mode,
  input  logic              rxd,
  input  logic              tick,
  input  logic              fall,
  output logic              arm,
  output logic              resync_en,
  output logic              done,
  output logic              stop_bad,
  output logic [DATA_W-1:0] frame_byte
);

  localparam int BCW = $clog2(DATA_W);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(DATA_W - 1);

  rx_state_e         state_q, state_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [BCW-1:0]    bit_q, bit_d;
  logic              shift_en;

  always_comb begin
    state_d  = state_q;
    bit_d    = bit_q;
    arm      = 1'b0;
    done     = 1'b0;
    shift_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        bit_d = '0;
        if (ovs_mode) begin
          if (fall) begin
            state_d = ST_START;
            arm     = 1'b1;
          end
        end else if (!rxd) begin
          state_d = ST_DATA;
        end
      end
      ST_START: begin
        if (tick) begin
          state_d = rxd ? ST_IDLE : ST_DATA;
        end
      end
      ST_DATA: begin
        if (tick) begin
          shift_en = 1'b1;
          bit_d    = bit_q + BCW'(1);
          if (bit_q == LAST_BIT) begin
            state_d = ST_STOP;
          end
        end
      end
      ST_STOP: begin
        if (tick) begin
          done    = 1'b1;
          state_d = ST_IDLE;
        end
      end
    endcase
  end

  assign sh_d       = {rxd, sh_q[DATA_W-1:1]};
  assign resync_en  = ovs_mode && ((state_q == ST_DATA) || (state_q == ST_STOP));
  assign stop_bad   = ~rxd;
  assign frame_byte = sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (shift_en) begin
      sh_q <= sh_d;
    end
  end

endmodule

// File: rtl/rx_hold_buf.sv
// Host-side holding register with ready, framing-error and overrun flags.
module rx_hold_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic              stop_bad,
  input  logic [DATA_W-1:0] frame_byte,
  input  logic              rd_data,
  input  logic              rd_stat,
  output logic [DATA_W-1:0] data_q,
  output logic              full_q,
  output logic              ferr_q,
  output logic              ovr_q
);

  logic accept, drop;
  logic full_d, ferr_d, ovr_d;

  assign accept = done && (!full_q || rd_data);
  assign drop   = done && full_q && !rd_data;

  always_comb begin
    full_d = full_q;
    if (accept) begin
      full_d = 1'b1;
    end else if (rd_data) begin
      full_d = 1'b0;
    end

    ferr_d = ferr_q;
    if (accept && stop_bad) begin
      ferr_d = 1'b1;
    end else if (rd_stat) begin
      ferr_d = 1'b0;
    end

    ovr_d = ovr_q;
    if (drop) begin
      ovr_d = 1'b1;
    end else if (rd_stat) begin
      ovr_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      ferr_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      full_q <= full_d;
      ferr_q <= ferr_d;
      ovr_q  <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (accept) begin
      data_q <= frame_byte;
    end
  end

endmodule

// File: rtl/async_rx_channel.sv
module async_rx_channel
  import rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              rx_clk,
  input  logic              rst_n,
  input  logic              div16_sel,
  input  logic              rxd,
  input  logic              rd_data,
  input  logic              rd_stat,
  output logic [DATA_W-1:0] data_out,
  output logic [STAT_W-1:0] stat_out,
  output logic              rx_ready,
  output logic              rx_error
);

  logic              rst_n_sync;
  logic              tick_w, fall_w, edge_w;
  logic              arm_w, resync_w;
  logic              done_w, stop_bad_w;
  logic [DATA_W-1:0] byte_w;
  logic              full_w, ferr_w, ovr_w;

  rx_reset_sync #(.STAGES(2)) u_rst (
    .clk    (rx_clk),
    .arst_n (rst_n),
    .srst_n (rst_n_sync)
  );

  rx_bit_timer #(.OVS(OVS)) u_timer (
    .clk       (rx_clk),
    .rst_n     (rst_n_sync),
    .ovs_mode  (div16_sel),
    .rxd       (rxd),
    .arm       (arm_w),
    .resync_en (resync_w),
    .tick      (tick_w),
    .fall      (fall_w),
    .line_edge (edge_w)
  );

  rx_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk        (rx_clk),
    .rst_n      (rst_n_sync),
    .ovs_mode   (div16_sel),
    .rxd        (rxd),
    .tick       (tick_w),
    .fall       (fall_w),
    .arm        (arm_w),
    .resync_en  (resync_w),
    .done       (done_w),
    .stop_bad   (stop_bad_w),
    .frame_byte (byte_w)
  );

  rx_hold_buf #(.DATA_W(DATA_W)) u_buf (
    .clk        (rx_clk),
    .rst_n      (rst_n_sync),
    .done       (done_w),
    .stop_bad   (stop_bad_w),
    .frame_byte (byte_w),
    .rd_data    (rd_data),
    .rd_stat    (rd_stat),
    .data_q     (data_out),
    .full_q     (full_w),
    .ferr_q     (ferr_w),
    .ovr_q      (ovr_w)
  );

  always_comb begin
    stat_out             = '0;
    stat_out[STAT_READY] = full_w;
    stat_out[STAT_FERR]  = ferr_w;
    stat_out[STAT_OVR]   = ovr_w;
  end

  assign rx_ready = full_w;
  assign rx_error = ferr_w | ovr_w;

endmodule

// File: rtl/rx_channel_chk.sv
module rx_channel_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              stop_bad,
  input logic [DATA_W-1:0] frame_byte,
  input logic              rd_data,
  input logic              rd_stat,
  input logic [DATA_W-1:0] data_out,
  input logic [7:0]        stat_out,
  input logic              rx_ready,
  input logic              rx_error
);

  // R8
  rd_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !done) |=> !rx_ready);

  // R7
  overrun_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rx_ready && !rd_data) |=> (stat_out[2] && $stable(data_out)));

  // R6
  load_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (!rx_ready || rd_data)) |=> (rx_ready && (data_out == $past(frame_byte))));

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(data_out));

  // R5
  ferr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && stop_bad && (!rx_ready || rd_data)) |=> stat_out[1]);

  // R9
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !done) |=> !rx_error);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_error && !rd_stat) |=> rx_error);

endmodule

bind async_rx_channel rx_channel_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (rx_clk),
  .rst_n      (rst_n_sync),
  .done       (done_w),
  .stop_bad   (stop_bad_w),
  .frame_byte (byte_w),
  .rd_data    (rd_data),
  .rd_stat    (rd_stat),
  .data_out   (data_out),
  .stat_out   (stat_out),
  .rx_ready   (rx_ready),
  .rx_error   (rx_error)
);

// File: tb/tb_async_rx_channel.sv
module tb_async_rx_channel;

  logic       clk;
  logic       rst_n;
  logic       div16_sel;
  logic       rxd;
  logic       rd_data;
  logic       rd_stat;
  logic [7:0] data_out;
  logic [7:0] stat_out;
  logic       rx_ready;
  logic       rx_error;

  int n_chk;
  int n_fail;
  int cyc;
  bit finished;
  logic ready_before;

  async_rx_channel dut (
    .rx_clk    (clk),
    .rst_n     (rst_n),
    .div16_sel (div16_sel),
    .rxd       (rxd),
    .rd_data   (rd_data),
    .rd_stat   (rd_stat),
    .data_out  (data_out),
    .stat_out  (stat_out),
    .rx_ready  (rx_ready),
    .rx_error  (rx_error)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] exp_stat(input bit full, input bit fe, input bit ov);
    return {5'b0, ov, fe, full};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  task automatic pulse_rd(input bit d, input bit s);
    @(negedge clk) rd_data = d; rd_stat = s;
    @(negedge clk) rd_data = 1'b0; rd_stat = 1'b0;
  endtask

  task automatic send_x1(input logic [7:0] b, input bit stop, input bit rd_at_stop,
                         input bit st_at_stop);
    @(negedge clk) rxd = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk) rxd = b[i];
    end
    @(negedge clk) rxd = stop; rd_data = rd_at_stop; rd_stat = st_at_stop;
    ready_before = rx_ready;
    @(negedge clk) rxd = 1'b1; rd_data = 1'b0; rd_stat = 1'b0;
  endtask

  task automatic hold_bit(input logic v, input int p, input bit rd);
    @(negedge clk) rxd = v; rd_data = rd;
    @(negedge clk) rd_data = 1'b0;
    repeat (p - 2) @(negedge clk);
  endtask

  task automatic send_x16(input logic [7:0] b, input bit stop, input int p, input int rd_bit);
    hold_bit(1'b0, p, 1'b0);
    for (int i = 0; i < 8; i++) begin
      hold_bit(b[i], p, (i == rd_bit));
    end
    hold_bit(stop, p, 1'b0);
    @(negedge clk) rxd = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_mode(input bit m);
    @(negedge clk) div16_sel = m;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0; finished = 1'b0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; div16_sel = 1'b0; rxd = 1'b1; rd_data = 1'b0; rd_stat = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 data in reset", data_out, 8'h00);
    chk("R1 stat in reset", stat_out, 8'h00);
    chk("R1 ready/error in reset", {rx_ready, rx_error}, 2'b00);
    @(negedge clk) rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 stat after release", stat_out, 8'h00);

    // R2 divide-by-one frame, ready appears on the stop edge only
    send_x1(8'hA5, 1'b1, 1'b0, 1'b0);
    chk("R2 not ready before stop edge", ready_before, 1'b0);
    chk("R2 x1 byte", data_out, 8'hA5);
    chk("R10 stat ready only", stat_out, exp_stat(1, 0, 0));
    pulse_rd(1'b1, 1'b0);
    chk("R8 read clears ready", stat_out, exp_stat(0, 0, 0));

    // R5 framing error, byte still delivered; R9 status read clears error only
    send_x1(8'h3C, 1'b0, 1'b0, 1'b0);
    chk("R5 ferr byte", data_out, 8'h3C);
    chk("R5 ferr stat", stat_out, exp_stat(1, 1, 0));
    chk("R10 rx_error on ferr", rx_error, 1'b1);
    pulse_rd(1'b0, 1'b1);
    chk("R9 stat read keeps ready", stat_out, exp_stat(1, 0, 0));
    pulse_rd(1'b1, 1'b0);

    // R7 overrun
    send_x1(8'h11, 1'b1, 1'b0, 1'b0);
    send_x1(8'h22, 1'b1, 1'b0, 1'b0);
    chk("R7 overrun keeps old byte", data_out, 8'h11);
    chk("R7 overrun stat", stat_out, exp_stat(1, 0, 1));
    chk("R10 rx_error on overrun", rx_error, 1'b1);
    pulse_rd(1'b0, 1'b1);
    chk("R9 overrun cleared", stat_out, exp_stat(1, 0, 0));
    pulse_rd(1'b1, 1'b0);

    // R8 read in the completion cycle
    send_x1(8'h33, 1'b1, 1'b0, 1'b0);
    send_x1(8'h44, 1'b1, 1'b1, 1'b0);
    chk("R8 coincident read loads new", data_out, 8'h44);
    chk("R8 coincident read stat", stat_out, exp_stat(1, 0, 0));
    pulse_rd(1'b1, 1'b0);

    // R9 status read while a framing error is set
    send_x1(8'h5D, 1'b0, 1'b0, 1'b1);
    chk("R9 set wins over status read", stat_out, exp_stat(1, 1, 0));
    pulse_rd(1'b1, 1'b1);
    chk("R9 cleared after read", stat_out, exp_stat(0, 0, 0));

    // R4 divide-by-16 nominal
    set_mode(1'b1);
    send_x16(8'h96, 1'b1, 16, -1);
    chk("R4 x16 byte", data_out, 8'h96);
    chk("R4 x16 stat", stat_out, exp_stat(1, 0, 0));
    pulse_rd(1'b1, 1'b0);

    // R3 false start
    @(negedge clk) rxd = 1'b0;
    repeat (3) @(negedge clk);
    @(negedge clk) rxd = 1'b1;
    repeat (60) @(negedge clk);
    chk("R3 glitch gives no char", stat_out, exp_stat(0, 0, 0));
    send_x16(8'h5A, 1'b1, 16, -1);
    chk("R3 next frame after glitch", data_out, 8'h5A);
    pulse_rd(1'b1, 1'b0);

    // R4 resync under skewed bit periods
    send_x16(8'h55, 1'b1, 18, -1);
    chk("R4 slow 0x55", data_out, 8'h55);
    pulse_rd(1'b1, 1'b0);
    send_x16(8'hAA, 1'b1, 14, -1);
    chk("R4 fast 0xAA", data_out, 8'hAA);
    pulse_rd(1'b1, 1'b0);
    send_x16(8'h55, 1'b1, 14, -1);
    chk("R4 fast 0x55", data_out, 8'h55);
    pulse_rd(1'b1, 1'b0);
    send_x16(8'hAA, 1'b1, 18, -1);
    chk("R4 slow 0xAA", data_out, 8'hAA);
    chk("R4 skew stat", stat_out, exp_stat(1, 0, 0));
    pulse_rd(1'b1, 1'b0);

    // R6 double buffer: read during next character
    send_x16(8'h01, 1'b1, 16, -1);
    send_x16(8'h02, 1'b1, 16, 4);
    chk("R6 second byte loaded", data_out, 8'h02);
    chk("R6 no overrun", stat_out, exp_stat(1, 0, 0));
    pulse_rd(1'b1, 1'b0);

    // random frames in both modes
    for (int k = 0; k < 40; k++) begin
      logic [7:0] b;
      bit m, s;
      b = 8'($urandom);
      m = 1'($urandom);
      s = (($urandom % 5) != 0);
      set_mode(m);
      if (m) send_x16(b, s, 16, -1);
      else   send_x1(b, s, 1'b0, 1'b0);
      chk(m ? "R4 random byte" : "R2 random byte", data_out, b);
      chk("R5 random stat", stat_out, exp_stat(1, !s, 0));
      pulse_rd(1'b0, 1'b1);
      chk("R9 random stat clear", stat_out, exp_stat(1, 0, 0));
      pulse_rd(1'b1, 1'b0);
      chk("R8 random read clear", rx_ready, 1'b0);
    end

    if (!finished) begin
      finished = 1'b1;
      summary();
      $finish;
    end
  end

endmodule